// File: doc/BRIEF.md
# Clockless One-Bit Audio Stream Receiver

This block receives up to eight parallel 1-bit delta-sigma audio streams. No bit clock comes with them. Each stream runs at 64 times a 44.1 kHz base rate, which is 2.8224 MHz. The block runs from a master clock at 512 times the base rate, so one stream bit lasts eight master clocks. Each lane passes its input through a two-flop synchroniser and then watches for transitions. A phase counter restarts on every transition and runs freely between transitions. The lane samples the line at mid-symbol.

A single format input sets the line coding for all lanes:

- **Raw format:** one symbol carries one bit.
- **Phase-coded format:** each bit spans two half-period symbols. The first half carries the bit value and the second half carries its complement.

In the phase-coded format the lane finds the bit boundary by itself. Within one bit the two halves always differ. So whenever two consecutive half-symbols are equal, a bit boundary lies between them.

A common strobe pulses once per bit period. At that strobe the recovered bit of every lane is presented together on a parallel output. A lane whose mute input is high outputs an alternating 1/0 pattern, which means zero signal, whatever its input does. Each lane also reports whether it has recently seen data transitions.

Top module: `onebit_stream_rx`

## Requirements
- R1: While reset is asserted (rst_n low), `bits_o`, `strobe_o` and every bit of `lock_o` are 0.
- R2: `strobe_o` is high for exactly one clock in every OSR (8) clocks, and never on two consecutive clocks.
- R3: `bits_o` changes only on a clock in which `strobe_o` is high.
- R4: With `fmt_raw_i` = 1, each lane recovers a raw stream in order and without loss or repetition, one bit per strobe, for any starting phase (0 to OSR-1 clocks) of the stream relative to the strobe. In the raw format each bit holds the line for OSR clocks.
- R5: With `fmt_raw_i` = 0, each bit b is sent as b for OSR/2 clocks followed by not-b for OSR/2 clocks. Each lane outputs b once per strobe, in order, after it has seen two consecutive bits that differ. This holds for any starting phase.
- R6: When `mute_i[c]` = 1, `bits_o[c]` alternates between 0 and 1 on successive strobes, independent of `din_i[c]` and of the format.
- R7: `lock_o[c]` rises after a transition on `din_i[c]`. It stays high while transitions keep arriving. It falls once LOCK_TIMEOUT (256) clocks pass without a transition.
- R8: Each lane follows only its own input: eight different simultaneous streams are each recovered on their own output bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, OSR ticks per stream bit |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_raw_i | input | 1 | 1 = raw line format, 0 = phase-coded format |
| mute_i | input | NCH | Per-lane mute, 1 = replace output with the alternating pattern |
| din_i | input | NCH | Serial stream inputs, asynchronous to clk phase |
| bits_o | output | NCH | Recovered bit per lane, updated with the strobe |
| strobe_o | output | 1 | One-clock pulse per bit period, common to all lanes |
| lock_o | output | NCH | Per-lane indication that transitions are being seen |

## Verification
The bench sweeps every starting phase of the stream against the strobe in both formats. A lane that samples too near a symbol edge, or re-centres wrongly, would drop or duplicate bits at some phases, and the lag search would then find no clean alignment.

In the phase-coded runs, a lane that never re-aligns on an equal half-symbol pair would output complemented or half-shifted data.

One lane per run is muted while its input still carries data, so a mute that leaks the input or stalls the pattern breaks the alternation.

Once the stream stops, the bench waits past the timeout and checks that lock falls. It also checks that lock is high at the end of traffic, which catches a timeout that is too short or never expires.

// File: rtl/obr_pkg.sv
package obr_pkg;

    typedef enum logic {
        FMT_PHASE = 1'b0,
        FMT_RAW   = 1'b1
    } line_fmt_e;

endpackage

// File: rtl/obr_sync.sv
module obr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/obr_lane.sv
module obr_lane #(
    parameter int OSR          = 8,
    parameter int LOCK_TIMEOUT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_mode,
    input  logic din,
    output logic bit_o,
    output logic lock_o
);
    localparam int CW = $clog2(OSR);
    localparam int TW = $clog2(LOCK_TIMEOUT);

    typedef struct packed {
        logic          prev;   // last synchronised level
        logic [CW-1:0] cnt;    // clocks since last edge, wraps per symbol
        logic          half;   // 1: next half-symbol is the second half
        logic          first;  // value of the first half of the current bit
        logic          last;   // previous half-symbol value
        logic          bitv;   // recovered bit
        logic [TW-1:0] idle;   // clocks without an edge
        logic          lock;
    } lane_t;

    lane_t lane_d, lane_q;
    logic s, edge_det, tick;
    logic [CW-1:0] sym_last, sample_pt;

    obr_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (din),
        .q     (s)
    );

    always_comb begin
        sym_last  = raw_mode ? CW'(OSR - 1) : CW'(OSR / 2 - 1);
        sample_pt = raw_mode ? CW'(OSR / 2) : CW'(OSR / 4);
        edge_det  = s ^ lane_q.prev;
        tick      = !edge_det && (lane_q.cnt == sample_pt);

        lane_d      = lane_q;
        lane_d.prev = s;

        if (edge_det)                    lane_d.cnt = '0;
        else if (lane_q.cnt >= sym_last) lane_d.cnt = '0;
        else                             lane_d.cnt = lane_q.cnt + CW'(1);

        if (tick) begin
            if (raw_mode) begin
                lane_d.bitv = s;
            end else begin
                lane_d.last = s;
                if (!lane_q.half || lane_q.last == s) begin
                    lane_d.first = s;
                    lane_d.half  = 1'b1;
                end else begin
                    lane_d.bitv = lane_q.first;
                    lane_d.half = 1'b0;
                end
            end
        end

        if (edge_det) begin
            lane_d.idle = '0;
            lane_d.lock = 1'b1;
        end else if (lane_q.idle == TW'(LOCK_TIMEOUT - 1)) begin
            lane_d.lock = 1'b0;
        end else begin
            lane_d.idle = lane_q.idle + TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign bit_o  = lane_q.bitv;
    assign lock_o = lane_q.lock;

    // R7: lock rises only after the synchroniser shows a transition
    a_r7_lock_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_q.lock) |-> $past(s) != $past(lane_q.prev));

    // R7: lock never drops in a cycle that carried a transition
    a_r7_lock_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lane_q.lock) |-> $past(s) == $past(lane_q.prev));
endmodule

// File: rtl/onebit_stream_rx.sv
module onebit_stream_rx #(
    parameter int NCH          = 8,
    parameter int OSR          = 8,
    parameter int LOCK_TIMEOUT = 256
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fmt_raw_i,
    input  logic [NCH-1:0] mute_i,
    input  logic [NCH-1:0] din_i,
    output logic [NCH-1:0] bits_o,
    output logic           strobe_o,
    output logic [NCH-1:0] lock_o
);
    import obr_pkg::*;

    localparam int SW = $clog2(OSR);

    typedef struct packed {
        logic [SW-1:0]  scnt;
        logic           strobe;
        logic           mpat;
        logic [NCH-1:0] bits;
    } top_t;

    top_t top_d, top_q;
    logic [NCH-1:0] lane_bit;
    logic raw_mode;

    assign raw_mode = (line_fmt_e'(fmt_raw_i) == FMT_RAW);

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        obr_lane #(.OSR(OSR), .LOCK_TIMEOUT(LOCK_TIMEOUT)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_mode (raw_mode),
            .din      (din_i[c]),
            .bit_o    (lane_bit[c]),
            .lock_o   (lock_o[c])
        );
    end

    always_comb begin
        top_d        = top_q;
        top_d.strobe = 1'b0;
        if (top_q.scnt == SW'(OSR - 1)) begin
            top_d.scnt   = '0;
            top_d.strobe = 1'b1;
            top_d.mpat   = ~top_q.mpat;
            for (int c = 0; c < NCH; c++)
                top_d.bits[c] = mute_i[c] ? top_q.mpat : lane_bit[c];
        end else begin
            top_d.scnt = top_q.scnt + SW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign bits_o   = top_q.bits;
    assign strobe_o = top_q.strobe;

    // R2: the strobe is a single-clock pulse
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    // R3: outputs move only together with the strobe
    a_r3_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_o |-> $stable(bits_o));
endmodule

// File: tb/onebit_stream_rx_test.sv
`timescale 1ns/1ps
module onebit_stream_rx_test;
    localparam int NCH = 8;
    localparam int OSR = 8;
    localparam int LT  = 256;
    localparam int NB  = 64;
    localparam int NR  = NB + 24;
    localparam int W   = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst_n;
    logic           fmt;
    logic [NCH-1:0] mute;
    logic [NCH-1:0] din;
    logic [NCH-1:0] bits_o;
    logic           strobe_o;
    logic [NCH-1:0] lock_o;

    onebit_stream_rx #(.NCH(NCH), .OSR(OSR), .LOCK_TIMEOUT(LT)) uut (
        .clk(clk), .rst_n(rst_n), .fmt_raw_i(fmt), .mute_i(mute),
        .din_i(din), .bits_o(bits_o), .strobe_o(strobe_o), .lock_o(lock_o)
    );

    int checks = 0;
    int fails  = 0;
    logic tx [NCH][NB];
    logic rx [NCH][NR];
    int gap_bad, hold_bad;
    logic [NCH-1:0] lock_end;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic patbit(input int c, input int j, input int seed);
        int x;
        x = j * 37 + c * 101 + seed * 13;
        x = x ^ (x >> 3);
        x = x * x + j;
        return x[5];
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        din   = '0;
        repeat (4) @(negedge clk);
        check(bits_o == '0 && strobe_o == 1'b0 && lock_o == '0, "R1",
              "reset state", {bits_o, strobe_o, lock_o}, 0);
        rst_n = 1'b1;
    endtask

    task automatic drive_stream(input int p, input bit raw);
        logic [NCH-1:0] v;
        repeat (p) @(negedge clk);
        for (int j = 0; j < NB; j++) begin
            for (int t = 0; t < OSR; t++) begin
                for (int c = 0; c < NCH; c++)
                    v[c] = raw ? tx[c][j] : ((t < OSR / 2) ? tx[c][j] : ~tx[c][j]);
                din = v;
                @(negedge clk);
            end
        end
        lock_end = lock_o;
    endtask

    task automatic collect();
        int n = 0;
        int cyc = 0;
        int last = -1;
        logic [NCH-1:0] prevb;
        prevb = bits_o;
        while (n < NR) begin
            @(negedge clk);
            cyc++;
            if (strobe_o) begin
                if (last >= 0 && cyc - last != OSR) gap_bad++;
                last = cyc;
                for (int c = 0; c < NCH; c++) rx[c][n] = bits_o[c];
                n++;
            end else if (bits_o != prevb) begin
                hold_bad++;
            end
            prevb = bits_o;
        end
    endtask

    task automatic scenario(input bit raw, input int p);
        int seed;
        string rq;
        seed = p * 7 + (raw ? 1 : 0);
        rq   = raw ? "R4 R8" : "R5 R8";
        for (int c = 0; c < NCH; c++) begin
            for (int j = 0; j < NB; j++) tx[c][j] = patbit(c, j, seed);
            tx[c][3] = ~tx[c][2];
        end
        fmt  = raw;
        mute = NCH'(1) << ((p + (raw ? 3 : 0)) % NCH);
        gap_bad  = 0;
        hold_bad = 0;
        do_reset();
        fork
            drive_stream(p, raw);
            collect();
        join
        check(gap_bad == 0, "R2", "strobe spacing errors", gap_bad, 0);
        check(hold_bad == 0, "R3", "bits changed without strobe", hold_bad, 0);
        for (int c = 0; c < NCH; c++) begin
            if (mute[c]) begin
                int bad = 0;
                for (int k = W; k < NR - 1; k++) if (rx[c][k] == rx[c][k+1]) bad++;
                check(bad == 0, "R6", $sformatf("muted lane %0d repeats", c), bad, 0);
            end else begin
                int best = NB;
                for (int L = 0; L <= NR - NB; L++) begin
                    int mm = 0;
                    for (int k = W; k < NB; k++) if (rx[c][k+L] != tx[c][k]) mm++;
                    if (mm < best) best = mm;
                end
                check(best == 0, rq, $sformatf("lane %0d phase %0d mismatches", c, p),
                      best, 0);
            end
        end
        check(lock_end == '1, "R7", "lock during traffic", lock_end, {NCH{1'b1}});
        repeat (LT + 20) @(negedge clk);
        check(lock_o == '0, "R7", "lock after silence", lock_o, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        fmt   = 1'b1;
        mute  = '0;
        din   = '0;
        for (int f = 1; f >= 0; f--)
            for (int p = 0; p < OSR; p++)
                scenario(f[0], p);
        summary();
        $finish;
    end
endmodule